// File: doc/BRIEF.md
# Dual-Bank NOR Flash Command Interpreter

This block is a synthesizable, cycle-based model of the command state machine in a two-bank NOR flash. It takes bus write cycles, each an address and a data word, and decodes unlock and command sequences from them. Program and erase run as countdown timers. While an operation runs, reads from the bank it occupies return a status word instead of array data. Reads from the other bank return array data at the normal latency.

The array is a scaled register file of 512 sixteen-bit words. It keeps the real sector layout: small boot sectors at the bottom of bank A, then large sectors filling the rest of bank A and all of bank B. Sector erase can be suspended, so that a word in another sector can be programmed, and then resumed. A per-sector lock vector and a boot-guard pin block changes to protected sectors. A synchronous hardware-reset input aborts any operation and returns the interpreter to read mode.

Both the write and read interfaces take one beat per clock and have no back-pressure. A write is captured in every cycle where `wr_en` is high. Every read issued with `rd_en` is answered exactly one cycle later. Control and status pins are plain levels.

Top module: `flashcmd_top`

## Requirements
- R1: After `rst_n` is released, `ready` is high, `rd_valid` is low, and every word reads FFFFh.
- R2: A read of word index `rd_addr` (bank A is words 0–127, bank B is words 128–511) returns `rd_valid` high with its data in the following cycle. If that bank is not busy, the data is the array word, even while the other bank is programming or erasing.
- R3: Programming takes four writes: AAh at 555h, 55h at 2AAh, A0h at 555h, and then the data at the target. The command byte is `wr_data[7:0]` and the word index is `wr_addr[8:0]`. On completion the word becomes its old value AND the new data.
- R4: `ready` falls in the cycle after the final command write. It stays low for exactly PROG_CYC, SERASE_CYC or CHIP_CYC cycles, for program, sector erase and chip erase respectively.
- R5: A read anywhere in a busy bank returns a status word. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bit 6 inverts on each successive status read. All other bits, including bit 2, are 0.
- R6: A write that does not continue a valid sequence returns the interpreter to read mode and is discarded. A later command needs the full unlock again.
- R7: A sector erase is AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any word of the sector. The sectors are: words 0–7 are one-word sectors 0–7; each later sector has 8 words (sectors 8–22 in bank A, 23–70 in bank B). On completion every word of the sector is FFFFh.
- R8: The same prefix followed by 10h at 555h is a chip erase. It makes both banks busy and, on completion, sets every word of every unprotected sector to FFFFh.
- R9: A program or sector erase aimed at a sector whose `sect_lock` bit is set, or at sector 0 or 1 while `boot_guard` is high, is ignored: `ready` stays high and the contents are unchanged.
- R10: A single write of B0h during a sector erase suspends it, and `ready` is high in the next cycle. Reads inside the suspended sector then return status with bit 7 = 1, bit 6 held constant, and bit 2 inverting on each such read. Other sectors return array data.
- R11: While an erase is suspended, a program to another sector runs normally and a program to the suspended sector is ignored. A single write of 30h resumes the erase: `ready` falls again and the sector is erased on completion.
- R12: A pulse on `hw_reset` aborts any operation, cancels any suspended erase and clears a partly entered sequence. `ready` is high in the next cycle, and the aborted target keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the array is set to FFFFh |
| hw_reset | input | 1 | Synchronous abort back to read mode; array kept |
| wr_en | input | 1 | Bus write strobe, one beat per cycle |
| wr_addr | input | 11 | Write address; command addresses are compared on all bits |
| wr_data | input | 16 | Write data; command byte in bits 7:0 |
| rd_en | input | 1 | Read request, one beat per cycle |
| rd_addr | input | 9 | Word index to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 16 | Array word or status word |
| boot_guard | input | 1 | Protects boot sectors 0 and 1 while high |
| sect_lock | input | 71 | Per-sector protection bits |
| ready | output | 1 | High when no program or erase is running |

## Verification
Reads are due one clock edge after `rd_en` is sampled. The bench raises `rd_en` just after a falling edge and picks up `rd_data` at the next falling edge. `ready` is sampled at the falling edge right after the final command write. From there the bench counts falling edges until `ready` returns and compares the count with the operation length, minus any cycles it spent on status reads in between. Ignored commands are checked by sampling `ready` in the cycle right after the rejected write and by reading the target word back.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;
  // Scaled sector geometry
  localparam int BOOT_SECTS  = 8;   // one-word boot sectors at the bottom
  localparam int BIG_WORDS   = 8;   // words per large sector
  localparam int BANKA_BIG   = 15;
  localparam int BANKB_BIG   = 48;
  localparam int GUARD_SECTS = 2;   // sectors covered by boot_guard
  localparam int NSECT       = BOOT_SECTS + BANKA_BIG + BANKB_BIG;
  localparam int BANKA_WORDS = BOOT_SECTS + BANKA_BIG * BIG_WORDS;
  localparam int WORDS       = BANKA_WORDS + BANKB_BIG * BIG_WORDS;
  localparam int AW          = $clog2(WORDS);
  localparam int SW          = $clog2(NSECT);
  localparam int CAW         = 11;
  localparam int DW          = 16;

  localparam logic [CAW-1:0] ADR_A = 11'h555;
  localparam logic [CAW-1:0] ADR_B = 11'h2AA;
  localparam logic [7:0] K_AA = 8'hAA;
  localparam logic [7:0] K_55 = 8'h55;
  localparam logic [7:0] K_PGM = 8'hA0;
  localparam logic [7:0] K_ERS = 8'h80;
  localparam logic [7:0] K_SEC = 8'h30;
  localparam logic [7:0] K_CHIP = 8'h10;
  localparam logic [7:0] K_SUSP = 8'hB0;

  typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_SERS, OP_CERS} op_t;

  function automatic logic [SW-1:0] sect_of(input logic [AW-1:0] w);
    int wi;
    wi = int'(w);
    if (wi < BOOT_SECTS) return SW'(wi);
    return SW'(BOOT_SECTS + (wi - BOOT_SECTS) / BIG_WORDS);
  endfunction

  function automatic logic bank_of(input logic [AW-1:0] w);
    return int'(w) >= BANKA_WORDS;
  endfunction
endpackage

// File: rtl/flashcmd_seq.sv
module flashcmd_seq
  import flashcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_reset,
  input  logic             wr_en,
  input  logic [CAW-1:0]   wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NSECT-1:0] prot,
  input  logic             run_busy,
  input  logic             run_sers,
  input  logic             susp_on,
  input  logic [SW-1:0]    susp_sect,
  output logic             start_prog,
  output logic             start_sers,
  output logic             start_cers,
  output logic             susp_req,
  output logic             resume_req,
  output logic [AW-1:0]    tgt_word,
  output logic [DW-1:0]    tgt_data
);
  typedef enum logic [2:0] {S_RD, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3} seq_t;
  seq_t st, st_nx;

  logic [7:0]    cb;
  logic [SW-1:0] ws;
  logic          at_a, at_b;

  assign cb       = wr_data[7:0];
  assign tgt_word = wr_addr[AW-1:0];
  assign tgt_data = wr_data;
  assign ws       = sect_of(wr_addr[AW-1:0]);
  assign at_a     = wr_addr == ADR_A;
  assign at_b     = wr_addr == ADR_B;

  always_comb begin
    st_nx      = st;
    start_prog = 1'b0;
    start_sers = 1'b0;
    start_cers = 1'b0;
    susp_req   = 1'b0;
    resume_req = 1'b0;
    if (wr_en) begin
      st_nx = S_RD;
      if (run_busy) begin
        susp_req = run_sers && cb == K_SUSP;
      end else begin
        case (st)
          S_RD: begin
            if (at_a && cb == K_AA) st_nx = S_U1;
            else resume_req = susp_on && cb == K_SEC;
          end
          S_U1: if (at_b && cb == K_55) st_nx = S_U2;
          S_U2: begin
            if (at_a && cb == K_PGM) st_nx = S_PGM;
            else if (at_a && cb == K_ERS && !susp_on) st_nx = S_E1;
          end
          S_PGM: start_prog = !prot[ws] && !(susp_on && ws == susp_sect);
          S_E1: if (at_a && cb == K_AA) st_nx = S_E2;
          S_E2: if (at_b && cb == K_55) st_nx = S_E3;
          S_E3: begin
            start_sers = cb == K_SEC && !prot[ws];
            start_cers = at_a && cb == K_CHIP;
          end
          default: st_nx = S_RD;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st <= S_RD;
    else if (hw_reset) st <= S_RD;
    else               st <= st_nx;
  end

  p_one_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_sers, start_cers, susp_req, resume_req}));
endmodule

// File: rtl/flashcmd_engine.sv
module flashcmd_engine
  import flashcmd_pkg::*;
#(
  parameter int PROG_CYC   = 20,
  parameter int SERASE_CYC = 60,
  parameter int CHIP_CYC   = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_reset,
  input  logic          start_prog,
  input  logic          start_sers,
  input  logic          start_cers,
  input  logic          susp_req,
  input  logic          resume_req,
  input  logic [AW-1:0] tgt_word,
  input  logic [DW-1:0] tgt_data,
  output op_t           run_kind,
  output logic [AW-1:0] run_word,
  output logic [DW-1:0] run_data,
  output logic          susp_on,
  output logic [SW-1:0] susp_sect,
  output logic [1:0]    bank_busy,
  output logic          done_prog,
  output logic          done_sers,
  output logic          done_cers
);
  localparam int MAXC = (CHIP_CYC > SERASE_CYC) ?
                        ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC) :
                        ((SERASE_CYC > PROG_CYC) ? SERASE_CYC : PROG_CYC);
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt, susp_cnt;
  logic [AW-1:0] susp_word;
  logic          fin;

  assign fin       = run_kind != OP_IDLE && cnt == CW'(1) && !hw_reset;
  assign done_prog = fin && run_kind == OP_PROG;
  assign done_sers = fin && run_kind == OP_SERS;
  assign done_cers = fin && run_kind == OP_CERS;
  assign susp_sect = sect_of(susp_word);

  always_comb begin
    bank_busy = 2'b00;
    case (run_kind)
      OP_PROG, OP_SERS: bank_busy[bank_of(run_word)] = 1'b1;
      OP_CERS:          bank_busy = 2'b11;
      default:          bank_busy = 2'b00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_kind  <= OP_IDLE;
      cnt       <= '0;
      run_word  <= '0;
      run_data  <= '0;
      susp_on   <= 1'b0;
      susp_cnt  <= '0;
      susp_word <= '0;
    end else if (hw_reset) begin
      run_kind <= OP_IDLE;
      cnt      <= '0;
      susp_on  <= 1'b0;
    end else if (run_kind != OP_IDLE) begin
      if (fin) begin
        run_kind <= OP_IDLE;
      end else if (susp_req && run_kind == OP_SERS) begin
        susp_on   <= 1'b1;
        susp_cnt  <= cnt;
        susp_word <= run_word;
        run_kind  <= OP_IDLE;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end else if (start_prog) begin
      run_kind <= OP_PROG;
      cnt      <= CW'(PROG_CYC);
      run_word <= tgt_word;
      run_data <= tgt_data;
    end else if (start_sers) begin
      run_kind <= OP_SERS;
      cnt      <= CW'(SERASE_CYC);
      run_word <= tgt_word;
    end else if (start_cers) begin
      run_kind <= OP_CERS;
      cnt      <= CW'(CHIP_CYC);
    end else if (resume_req && susp_on) begin
      run_kind <= OP_SERS;
      cnt      <= susp_cnt;
      run_word <= susp_word;
      susp_on  <= 1'b0;
    end
  end

  p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_sers || start_cers) && !hw_reset |=> run_kind != OP_IDLE);
  p_timer_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_kind != OP_IDLE && !fin && !hw_reset && !susp_req) |=> cnt == $past(cnt) - CW'(1));
  p_hwreset_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reset |=> run_kind == OP_IDLE && !susp_on);
  p_susp_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_kind == OP_SERS && susp_req && !fin && !hw_reset) |=> run_kind == OP_IDLE && susp_on);
endmodule

// File: rtl/flashcmd_array.sv
module flashcmd_array
  import flashcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_prog,
  input  logic             done_sers,
  input  logic             done_cers,
  input  op_t              run_kind,
  input  logic [AW-1:0]    run_word,
  input  logic [DW-1:0]    run_data,
  input  logic [NSECT-1:0] prot,
  input  logic [1:0]       bank_busy,
  input  logic             susp_on,
  input  logic [SW-1:0]    susp_sect,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] mem [WORDS];
  logic [SW-1:0] run_sect;
  logic          rbusy, rsusp, dq7, tog6, tog2;

  assign run_sect = sect_of(run_word);
  assign rbusy    = bank_busy[bank_of(rd_addr)];
  assign rsusp    = susp_on && sect_of(rd_addr) == susp_sect;
  assign dq7      = (run_kind == OP_PROG) ? ~run_data[7] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (done_prog && run_word == AW'(i))                mem[i] <= mem[i] & run_data;
        else if (done_sers && sect_of(AW'(i)) == run_sect)  mem[i] <= '1;
        else if (done_cers && !prot[sect_of(AW'(i))])       mem[i] <= '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      tog6     <= 1'b0;
      tog2     <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (rbusy) begin
          rd_data <= {{(DW-8){1'b0}}, dq7, tog6, 3'b000, 1'b0, 2'b00};
          tog6    <= ~tog6;
        end else if (rsusp) begin
          rd_data <= {{(DW-8){1'b0}}, 1'b1, tog6, 3'b000, tog2, 2'b00};
          tog2    <= ~tog2;
        end else begin
          rd_data <= mem[rd_addr];
        end
      end
    end
  end

  p_rdvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_idle_bank_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rbusy && !rsusp && !done_prog && !done_sers && !done_cers
    |=> rd_data == $past(mem[rd_addr]));
endmodule

// File: rtl/flashcmd_top.sv
module flashcmd_top
  import flashcmd_pkg::*;
#(
  parameter int PROG_CYC   = 20,
  parameter int SERASE_CYC = 60,
  parameter int CHIP_CYC   = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_reset,
  input  logic             wr_en,
  input  logic [CAW-1:0]   wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  input  logic             boot_guard,
  input  logic [NSECT-1:0] sect_lock,
  output logic             ready
);
  logic [NSECT-1:0] prot;
  logic             start_prog, start_sers, start_cers, susp_req, resume_req;
  logic [AW-1:0]    tgt_word, run_word;
  logic [DW-1:0]    tgt_data, run_data;
  op_t              run_kind;
  logic             susp_on, done_prog, done_sers, done_cers;
  logic [SW-1:0]    susp_sect;
  logic [1:0]       bank_busy;

  always_comb begin
    prot = sect_lock;
    for (int s = 0; s < GUARD_SECTS; s++) if (boot_guard) prot[s] = 1'b1;
  end

  assign ready = run_kind == OP_IDLE;

  flashcmd_seq u_seq (
    .clk, .rst_n, .hw_reset, .wr_en, .wr_addr, .wr_data, .prot,
    .run_busy (run_kind != OP_IDLE),
    .run_sers (run_kind == OP_SERS),
    .susp_on, .susp_sect,
    .start_prog, .start_sers, .start_cers, .susp_req, .resume_req,
    .tgt_word, .tgt_data
  );

  flashcmd_engine #(
    .PROG_CYC (PROG_CYC), .SERASE_CYC (SERASE_CYC), .CHIP_CYC (CHIP_CYC)
  ) u_engine (
    .clk, .rst_n, .hw_reset, .start_prog, .start_sers, .start_cers,
    .susp_req, .resume_req, .tgt_word, .tgt_data,
    .run_kind, .run_word, .run_data, .susp_on, .susp_sect, .bank_busy,
    .done_prog, .done_sers, .done_cers
  );

  flashcmd_array u_array (
    .clk, .rst_n, .done_prog, .done_sers, .done_cers, .run_kind,
    .run_word, .run_data, .prot, .bank_busy, .susp_on, .susp_sect,
    .rd_en, .rd_addr, .rd_valid, .rd_data
  );
endmodule

// File: tb/flashcmd_top_tb.sv
module flashcmd_top_tb;
  localparam int PROG_CYC = 20, SERASE_CYC = 60, CHIP_CYC = 100;

  logic        clk = 1'b0, rst_n = 1'b0, hw_reset = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, boot_guard = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [8:0]  rd_addr = '0;
  logic [70:0] sect_lock = '0;
  logic        rd_valid, ready;
  logic [15:0] rd_data;

  logic [15:0] model [512];
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  flashcmd_top #(.PROG_CYC(PROG_CYC), .SERASE_CYC(SERASE_CYC), .CHIP_CYC(CHIP_CYC)) u_dut (
    .clk, .rst_n, .hw_reset, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr,
    .rd_valid, .rd_data, .boot_guard, .sect_lock, .ready
  );

  function automatic int bsect(int w);
    return (w < 8) ? w : 8 + (w - 8) / 8;
  endfunction
  function automatic bit bprot(int w);
    return sect_lock[bsect(w)] || (boot_guard && bsect(w) < 2);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int w, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = 9'(w);
    @(negedge clk);
    rd_en = 1'b0; d = rd_data;
  endtask

  task automatic prog(input int w, input logic [15:0] d);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(11'(w), d);
  endtask

  task automatic erase_pre();
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (ready !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic model_prog(input int w, input logic [15:0] d);
    if (!bprot(w)) model[w] = model[w] & d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v, s1, s2;
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ready == 1'b1, "R1 ready after reset", 16'(ready), 16'h1);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", 16'(rd_valid), 16'h0);
    rd(0, v);   chk(v == 16'hFFFF, "R1 word 0", v, 16'hFFFF);
    chk(rd_valid == 1'b1, "R2 rd_valid one cycle after rd_en", 16'(rd_valid), 16'h1);
    rd(511, v); chk(v == 16'hFFFF, "R1 word 511", v, 16'hFFFF);

    // R3 R4 R5 directed program with status reads
    prog(20, 16'h1234);
    chk(ready == 1'b0, "R4 ready low after program", 16'(ready), 16'h0);
    rd(25, s1); rd(20, s2);
    chk((s1 & 16'hFF3B) == 0 && s1[7] == 1'b1, "R5 program status bits", s1, 16'h0080);
    chk(s2[6] != s1[6] && s2[2] == 1'b0, "R5 DQ6 inverts", s2, s1 ^ 16'h0040);
    wait_ready(n);
    chk(n == PROG_CYC - 2, "R4 program length", 16'(n), 16'(PROG_CYC - 2));
    model_prog(20, 16'h1234);
    rd(20, v); chk(v == model[20], "R3 programmed word", v, model[20]);
    prog(20, 16'hFF0F); wait_ready(n); model_prog(20, 16'hFF0F);
    rd(20, v); chk(v == model[20], "R3 AND of old and new", v, model[20]);

    // R9 random phase with locks and boot guard, R2 other-bank reads
    sect_lock[30] = 1'b1; sect_lock[60] = 1'b1; boot_guard = 1'b1;
    for (int it = 0; it < 40; it++) begin
      int w, ow;
      logic [15:0] d;
      w  = (it % 5 == 0) ? (it % 2 == 0 ? 184 + it % 8 : it % 2) : int'($urandom_range(0, 511));
      d  = 16'($urandom);
      ow = (w < 128) ? int'($urandom_range(128, 511)) : int'($urandom_range(0, 127));
      prog(w, d);
      if (bprot(w)) begin
        chk(ready == 1'b1, "R9 protected program ignored", 16'(ready), 16'h1);
      end else begin
        rd(ow, v); chk(v == model[ow], "R2 other bank reads array while busy", v, model[ow]);
        wait_ready(n);
        chk(n == PROG_CYC - 1, "R4 program length random", 16'(n), 16'(PROG_CYC - 1));
        model_prog(w, d);
      end
      rd(w, v); chk(v == model[w], "R3 R9 random word", v, model[w]);
    end

    // R9 boot guard edge: sector 2 writable, sector 1 after guard release
    prog(2, 16'h00F0); wait_ready(n); model_prog(2, 16'h00F0);
    rd(2, v); chk(v == model[2], "R9 sector 2 not guarded", v, model[2]);
    boot_guard = 1'b0;
    prog(1, 16'h0F0F); wait_ready(n); model_prog(1, 16'h0F0F);
    rd(1, v); chk(v == model[1], "R9 sector 1 after guard release", v, model[1]);

    // R6 broken sequence
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd50, 16'h0000);
    chk(ready == 1'b1, "R6 broken sequence no busy", 16'(ready), 16'h1);
    rd(50, v); chk(v == model[50], "R6 broken sequence word kept", v, model[50]);

    // R7 sector erase, neighbours kept
    prog(295, 16'h1111); wait_ready(n); model_prog(295, 16'h1111);
    prog(304, 16'h2222); wait_ready(n); model_prog(304, 16'h2222);
    prog(300, 16'h3333); wait_ready(n); model_prog(300, 16'h3333);
    erase_pre(); wr(11'd300, 16'h0030);
    chk(ready == 1'b0, "R4 ready low after erase", 16'(ready), 16'h0);
    wait_ready(n);
    chk(n == SERASE_CYC, "R4 sector erase length", 16'(n), 16'(SERASE_CYC));
    for (int w = 296; w < 304; w++) model[w] = 16'hFFFF;
    rd(300, v); chk(v == 16'hFFFF, "R7 sector erased", v, 16'hFFFF);
    rd(295, v); chk(v == model[295], "R7 lower neighbour kept", v, model[295]);
    rd(304, v); chk(v == model[304], "R7 upper neighbour kept", v, model[304]);
    erase_pre(); wr(11'd186, 16'h0030);
    chk(ready == 1'b1, "R9 locked sector erase ignored", 16'(ready), 16'h1);

    // R10 R11 suspend and resume
    prog(400, 16'h0A0A); wait_ready(n); model_prog(400, 16'h0A0A);
    prog(410, 16'h5050); wait_ready(n); model_prog(410, 16'h5050);
    erase_pre(); wr(11'd400, 16'h0030);
    repeat (5) @(negedge clk);
    wr(11'd403, 16'h00B0);
    chk(ready == 1'b1, "R10 ready high in suspend", 16'(ready), 16'h1);
    rd(400, s1); rd(405, s2);
    chk(s1[7] == 1'b1 && (s1 & 16'hFF3B) == 0, "R10 suspended status bits", s1, 16'h0080);
    chk(s2[2] != s1[2] && s2[6] == s1[6], "R10 DQ2 toggles DQ6 holds", s2, s1 ^ 16'h0004);
    rd(410, v); chk(v == model[410], "R10 other sector array data", v, model[410]);
    prog(415, 16'h7777);
    wait_ready(n); model_prog(415, 16'h7777);
    chk(n == PROG_CYC, "R11 program during suspend length", 16'(n), 16'(PROG_CYC));
    rd(415, v); chk(v == model[415], "R11 program during suspend", v, model[415]);
    prog(401, 16'h0000);
    chk(ready == 1'b1, "R11 program to suspended sector ignored", 16'(ready), 16'h1);
    wr(11'd400, 16'h0030);
    chk(ready == 1'b0, "R11 resume drops ready", 16'(ready), 16'h0);
    wait_ready(n);
    chk(n > 0 && n <= SERASE_CYC, "R11 resumed erase finishes", 16'(n), 16'(SERASE_CYC));
    for (int w = 400; w < 408; w++) model[w] = 16'hFFFF;
    rd(401, v); chk(v == 16'hFFFF, "R11 suspended sector erased", v, 16'hFFFF);
    rd(410, v); chk(v == model[410], "R11 other sector kept", v, model[410]);

    // R8 chip erase with a locked sector
    prog(300, 16'h1234); wait_ready(n); model_prog(300, 16'h1234);
    sect_lock[44] = 1'b1;
    erase_pre(); wr(11'h555, 16'h0010);
    rd(10, s1); rd(450, s2);
    chk((s1 & 16'hFFBB) == 0, "R8 bank A busy status", s1, 16'h0000);
    chk((s2 & 16'hFFBB) == 0, "R8 bank B busy status", s2, 16'h0000);
    wait_ready(n);
    chk(n == CHIP_CYC - 2, "R4 chip erase length", 16'(n), 16'(CHIP_CYC - 2));
    for (int w = 0; w < 512; w++) if (!bprot(w)) model[w] = 16'hFFFF;
    for (int w = 0; w < 512; w += 37) begin
      rd(w, v); chk(v == model[w], "R8 chip erase word", v, model[w]);
    end
    rd(300, v); chk(v == model[300], "R8 locked sector kept", v, model[300]);
    rd(186, v); chk(v == model[186], "R8 second locked sector kept", v, model[186]);

    // R12 hardware reset
    prog(60, 16'h0000);
    hw_reset = 1'b1; @(negedge clk); hw_reset = 1'b0;
    chk(ready == 1'b1, "R12 ready after hw_reset", 16'(ready), 16'h1);
    repeat (PROG_CYC + 2) @(negedge clk);
    rd(60, v); chk(v == model[60], "R12 aborted word kept", v, model[60]);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055);
    hw_reset = 1'b1; @(negedge clk); hw_reset = 1'b0;
    wr(11'h555, 16'h00A0); wr(11'd60, 16'h0000);
    chk(ready == 1'b1, "R12 partial sequence cleared", 16'(ready), 16'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule